// File: doc/BRIEF.md
# Debug Trace Line Store

This block is a 64-line store for 20-bit trace lines. It sits next to a processor debug unit. While the unit is armed, each trace line that arrives with a valid strobe is written into a circular array. A 6-bit count of stored lines is kept up to date, and a full flag is set once the count has wrapped. Software arms and disarms the store through a control write. Arming clears the count and the full flag, and it locks the store against reading.

After the unit is disarmed, software unlocks the store by writing an aligned word to a 16-bit window. It then reads the lines back through that window, two reads per line. A read pointer advances only on qualified reads and wraps around the array. Reads are refused while the unit is armed, while the store is locked, while the trace-source enable is low, or when the access is not an aligned word. A refused read returns zero and leaves the pointer where it was.

There are two reset domains. Power-on reset clears the count and the full flag. The system reset leaves the count, the full flag and the stored lines alone, so a session can still be read out after a reset in the middle of it.

Top module: `trace_store`

## Requirements
- R1: While armed, each cycle with `trc_valid` high stores `trc_line` at array position `cnt_o` and increments `cnt_o` by one, modulo 64.
- R2: A store made when `cnt_o` is 63 sets `full_o`. `full_o` then stays set until the next arming write, and `cnt_o` keeps counting from 0.
- R3: A control write with `ctl_arm`=1 arms the store, clears `cnt_o` and `full_o` on the next edge, and drops any line offered in that same cycle. A control write with `ctl_arm`=0 disarms the store.
- R4: While disarmed, offered lines are not stored and `cnt_o` and `full_o` hold their values. Window reads never decrement `cnt_o`.
- R5: A window read while armed returns 0 and does not move the read position.
- R6: A window read with `src_en` low returns 0 and does not move the read position.
- R7: A window read with `win_word`=0 (a byte-sized or misaligned access) returns 0 and does not move the read position.
- R8: Arming and either reset lock the store, and a locked store returns 0 on every read without moving the read position. Only a window write with `win_word`=1 while disarmed removes the lock. A window read in the same cycle as a window write returns 0.
- R9: A line is returned by two qualified reads. The first returns bits 19:16 of the line in bits 3:0, with bits 15:4 zero. The second returns bits 15:0. The position then advances, wrapping from 63 to 0.
- R10: The unlocking write sets the read position to the oldest line: 0 when `full_o` is clear, `cnt_o` when it is set. The first read after it returns the upper part of that line.
- R11: With `por_n` low, `cnt_o` and `full_o` clear. With only `rst_n` low, the store disarms and locks, but `cnt_o`, `full_o` and the stored lines are kept. Control writes are ignored while `rst_n` is low.
- R12: `stat_o` bit 7 mirrors `full_o`, bit 0 mirrors `armed_o`, and bits 6:1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| rst_n | input | 1 | System reset, active low, synchronous |
| ctl_wr | input | 1 | Control write strobe |
| ctl_arm | input | 1 | Arm value carried by a control write |
| src_en | input | 1 | Trace-source enable; reads are refused when low |
| trc_valid | input | 1 | Trace line strobe |
| trc_line | input | 20 | Trace line data |
| win_rd | input | 1 | Window read strobe |
| win_wr | input | 1 | Window write strobe (unlock request) |
| win_word | input | 1 | Access is an aligned 16-bit word |
| win_rdata | output | 16 | Window read data, valid in the cycle of `win_rd` |
| cnt_o | output | 6 | Number of stored lines, modulo 64 |
| full_o | output | 1 | Count has wrapped since arming |
| armed_o | output | 1 | Store is armed |
| stat_o | output | 8 | Status byte: full flag on top, armed state at bit 0 |

## Verification
A corrupted count shows at `cnt_o` one edge after the store that caused it. It also moves the start position of the next full readout, so every later word comes out of the wrong line. A lost or stray phase toggle in the readout sequence makes upper-nibble and lower-half words change places. This shows on the very next qualified read, as nonzero data in bits 15:4 or as a mismatch against the line pushed earlier. A lock or arm bit that is wrongly held shows as zero data on the first read after unlock, or as nonzero data where zero was required, within one cycle of the access.

// File: rtl/trs_pkg.sv
package trs_pkg;

   // readout phase of one trace line through the narrow window
   typedef enum logic {
      PH_UPPER = 1'b0,
      PH_LOWER = 1'b1
   } phase_e;

   // qualified access strobes produced by the control unit
   typedef struct packed {
      logic arm_clr;   // arming write accepted: clear count/flag, lock
      logic unlock;    // aligned word write while disarmed
      logic rd_ok;     // read permitted to return data and advance
   } acc_t;

endpackage

// File: rtl/trs_ctrl.sv
module trs_ctrl
   import trs_pkg::*;
(
   input  logic clk,
   input  logic por_n,
   input  logic rst_n,
   input  logic ctl_wr,
   input  logic ctl_arm,
   input  logic src_en,
   input  logic win_rd,
   input  logic win_wr,
   input  logic win_word,
   output logic armed,
   output acc_t acc
);

   logic any_rst;
   logic locked;

   assign any_rst = !por_n || !rst_n;

   always_comb begin
      acc.arm_clr = ctl_wr && ctl_arm && !any_rst;
      acc.unlock  = win_wr && win_word && !armed && !any_rst;
      acc.rd_ok   = win_rd && !win_wr && win_word && src_en
                    && !armed && !locked && !any_rst;
   end

   always_ff @(posedge clk) begin
      if (any_rst)
         armed <= 1'b0;
      else if (ctl_wr)
         armed <= ctl_arm;
   end

   always_ff @(posedge clk) begin
      if (any_rst)
         locked <= 1'b1;
      else if (acc.arm_clr)
         locked <= 1'b1;
      else if (acc.unlock)
         locked <= 1'b0;
   end

endmodule

// File: rtl/trs_fill.sv
module trs_fill #(
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          rst_n,
   input  logic          armed,
   input  logic          arm_clr,
   input  logic          trc_valid,
   output logic          wr_en,
   output logic [AW-1:0] cnt,
   output logic          full
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   assign wr_en = armed && trc_valid && rst_n && !arm_clr;

   // power-on domain only: system reset must not disturb these
   always_ff @(posedge clk) begin
      if (!por_n) begin
         cnt  <= '0;
         full <= 1'b0;
      end else if (arm_clr) begin
         cnt  <= '0;
         full <= 1'b0;
      end else if (wr_en) begin
         cnt <= cnt + 1'b1;
         if (cnt == LAST)
            full <= 1'b1;
      end
   end

endmodule

// File: rtl/trs_mem.sv
module trs_mem #(
   parameter int LINE_W = 20,
   parameter int DEPTH  = 64,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [LINE_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [LINE_W-1:0] rdata
);

   // no reset: contents after power-up are undefined by design
   logic [LINE_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/trs_read.sv
module trs_read
   import trs_pkg::*;
#(
   parameter int LINE_W = 20,
   parameter int BUS_W  = 16,
   parameter int DEPTH  = 64,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              rd_ok,
   input  logic              unlock,
   input  logic              full,
   input  logic [AW-1:0]     cnt,
   input  logic [LINE_W-1:0] line,
   output logic [AW-1:0]     rptr,
   output logic [BUS_W-1:0]  rdata
);

   localparam bit SPLIT = LINE_W > BUS_W;

   logic any_rst;
   logic advance;

   assign any_rst = !por_n || !rst_n;

   generate
      if (SPLIT) begin : g_two_phase
         localparam int HI_W = LINE_W - BUS_W;
         phase_e           phase;
         logic [BUS_W-1:0] hi_ext;

         always_comb begin
            hi_ext = '0;
            hi_ext[HI_W-1:0] = line[LINE_W-1:BUS_W];
         end

         always_comb begin
            rdata = '0;
            if (rd_ok)
               rdata = (phase == PH_UPPER) ? hi_ext : line[BUS_W-1:0];
         end

         assign advance = rd_ok && (phase == PH_LOWER);

         always_ff @(posedge clk) begin
            if (any_rst || unlock)
               phase <= PH_UPPER;
            else if (rd_ok)
               phase <= (phase == PH_UPPER) ? PH_LOWER : PH_UPPER;
         end
      end else begin : g_one_phase
         logic [BUS_W-1:0] ext;

         always_comb begin
            ext = '0;
            ext[LINE_W-1:0] = line;
         end

         assign rdata   = rd_ok ? ext : '0;
         assign advance = rd_ok;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (any_rst)
         rptr <= '0;
      else if (unlock)
         rptr <= full ? cnt : '0;
      else if (advance)
         rptr <= rptr + 1'b1;
   end

endmodule

// File: rtl/trace_store.sv
module trace_store
   import trs_pkg::*;
#(
   parameter int LINE_W = 20,
   parameter int BUS_W  = 16,
   parameter int DEPTH  = 64,
   parameter int STAT_W = 8,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic              ctl_arm,
   input  logic              src_en,
   input  logic              trc_valid,
   input  logic [LINE_W-1:0] trc_line,
   input  logic              win_rd,
   input  logic              win_wr,
   input  logic              win_word,
   output logic [BUS_W-1:0]  win_rdata,
   output logic [AW-1:0]     cnt_o,
   output logic              full_o,
   output logic              armed_o,
   output logic [STAT_W-1:0] stat_o
);

   // elaboration-time parameter checks
   generate
      if (DEPTH < 2 || DEPTH != (1 << AW)) begin : g_bad_depth
         $error("trace_store: DEPTH must be a power of two, at least 2");
      end
      if (LINE_W > 2 * BUS_W) begin : g_bad_width
         $error("trace_store: LINE_W must fit in two window words");
      end
      if (STAT_W < 2) begin : g_bad_stat
         $error("trace_store: STAT_W must be at least 2");
      end
   endgenerate

   acc_t              acc;
   logic              armed;
   logic              wr_en;
   logic [AW-1:0]     cnt;
   logic              full;
   logic [AW-1:0]     rptr;
   logic [LINE_W-1:0] rline;

   trs_ctrl u_ctrl (
      .clk      (clk),
      .por_n    (por_n),
      .rst_n    (rst_n),
      .ctl_wr   (ctl_wr),
      .ctl_arm  (ctl_arm),
      .src_en   (src_en),
      .win_rd   (win_rd),
      .win_wr   (win_wr),
      .win_word (win_word),
      .armed    (armed),
      .acc      (acc)
   );

   trs_fill #(.DEPTH(DEPTH)) u_fill (
      .clk       (clk),
      .por_n     (por_n),
      .rst_n     (rst_n),
      .armed     (armed),
      .arm_clr   (acc.arm_clr),
      .trc_valid (trc_valid),
      .wr_en     (wr_en),
      .cnt       (cnt),
      .full      (full)
   );

   trs_mem #(.LINE_W(LINE_W), .DEPTH(DEPTH)) u_mem (
      .clk   (clk),
      .we    (wr_en),
      .waddr (cnt),
      .wdata (trc_line),
      .raddr (rptr),
      .rdata (rline)
   );

   trs_read #(.LINE_W(LINE_W), .BUS_W(BUS_W), .DEPTH(DEPTH)) u_read (
      .clk    (clk),
      .por_n  (por_n),
      .rst_n  (rst_n),
      .rd_ok  (acc.rd_ok),
      .unlock (acc.unlock),
      .full   (full),
      .cnt    (cnt),
      .line   (rline),
      .rptr   (rptr),
      .rdata  (win_rdata)
   );

   assign cnt_o   = cnt;
   assign full_o  = full;
   assign armed_o = armed;

   always_comb begin
      stat_o            = '0;
      stat_o[STAT_W-1]  = full;
      stat_o[0]         = armed;
   end

endmodule

// File: rtl/trs_chk.sv
module trs_chk #(
   parameter int BUS_W = 16,
   parameter int AW    = 6
) (
   input logic             clk,
   input logic             por_n,
   input logic             rst_n,
   input logic             ctl_wr,
   input logic             ctl_arm,
   input logic             src_en,
   input logic             trc_valid,
   input logic             win_rd,
   input logic             win_word,
   input logic [BUS_W-1:0] win_rdata,
   input logic [AW-1:0]    cnt_o,
   input logic             full_o,
   input logic             armed_o
);

   logic arm1;
   assign arm1 = ctl_wr && ctl_arm && rst_n;

   a_r1_count_step: assert property (@(posedge clk) disable iff (!por_n)
      (armed_o && trc_valid && rst_n && !arm1) |=> (cnt_o == AW'($past(cnt_o) + 1'b1)));

   a_r2_full_on_wrap: assert property (@(posedge clk) disable iff (!por_n)
      (armed_o && trc_valid && rst_n && !arm1 && cnt_o == '1) |=> full_o);

   a_r2_full_sticky: assert property (@(posedge clk) disable iff (!por_n)
      (full_o && !arm1) |=> full_o);

   a_r3_arm_clears: assert property (@(posedge clk) disable iff (!por_n)
      arm1 |=> (cnt_o == '0 && !full_o));

   a_r4_idle_hold: assert property (@(posedge clk) disable iff (!por_n)
      (!armed_o && !arm1) |=> ($stable(cnt_o) && $stable(full_o)));

   a_r5_armed_read_zero: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (win_rd && armed_o) |-> (win_rdata == '0));

   a_r6_src_off_zero: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (win_rd && !src_en) |-> (win_rdata == '0));

   a_r7_narrow_zero: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (win_rd && !win_word) |-> (win_rdata == '0));

   a_r11_sysrst_disarms: assert property (@(posedge clk) disable iff (!por_n)
      (!rst_n) |=> !armed_o);

endmodule

bind trace_store trs_chk #(.BUS_W(BUS_W), .AW(AW)) i_chk (
   .clk       (clk),
   .por_n     (por_n),
   .rst_n     (rst_n),
   .ctl_wr    (ctl_wr),
   .ctl_arm   (ctl_arm),
   .src_en    (src_en),
   .trc_valid (trc_valid),
   .win_rd    (win_rd),
   .win_word  (win_word),
   .win_rdata (win_rdata),
   .cnt_o     (cnt_o),
   .full_o    (full_o),
   .armed_o   (armed_o)
);

// File: tb/test_trace_store.sv
module test_trace_store;

   localparam int LW = 20;
   localparam int BW = 16;
   localparam int DP = 64;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          por_n, rst_n, ctl_wr, ctl_arm, src_en, trc_valid;
   logic [LW-1:0] trc_line;
   logic          win_rd, win_wr, win_word;
   logic [BW-1:0] win_rdata;
   logic [AW-1:0] cnt_o;
   logic          full_o, armed_o;
   logic [7:0]    stat_o;

   always #10 clk = ~clk;   // 50 MHz

   trace_store i_trace_store (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_arm(ctl_arm),
      .src_en(src_en), .trc_valid(trc_valid), .trc_line(trc_line),
      .win_rd(win_rd), .win_wr(win_wr), .win_word(win_word), .win_rdata(win_rdata),
      .cnt_o(cnt_o), .full_o(full_o), .armed_o(armed_o), .stat_o(stat_o)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // requirement-level model
   logic [LW-1:0] m_mem [DP];
   int  m_cnt;
   bit  m_full, m_armed, m_locked, m_half;
   int  m_rptr;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      ctl_wr = 0; ctl_arm = 0; trc_valid = 0; win_rd = 0; win_wr = 0; win_word = 1;
   endtask

   function automatic logic [BW-1:0] exp_word(logic [LW-1:0] ln, bit lower);
      return lower ? ln[15:0] : {12'h000, ln[19:16]};
   endfunction

   task automatic do_por();
      por_n = 0; rst_n = 0; idle();
      repeat (3) cyc();
      por_n = 1; rst_n = 1;
      m_cnt = 0; m_full = 0; m_armed = 0; m_locked = 1; m_half = 0; m_rptr = 0;
   endtask

   task automatic do_sysrst();
      rst_n = 0; idle();
      ctl_wr = 1; ctl_arm = 1;   // must be ignored during reset
      repeat (2) cyc();
      rst_n = 1; idle();
      m_armed = 0; m_locked = 1; m_half = 0; m_rptr = 0;
   endtask

   task automatic arm_wr(bit v, bit with_line);
      ctl_wr = 1; ctl_arm = v;
      trc_valid = with_line; trc_line = LW'($urandom);
      cyc();
      idle();
      m_armed = v;
      if (v) begin m_cnt = 0; m_full = 0; m_locked = 1; end
   endtask

   task automatic push(logic [LW-1:0] ln);
      trc_valid = 1; trc_line = ln;
      cyc();
      trc_valid = 0;
      if (m_armed) begin
         m_mem[m_cnt] = ln;
         if (m_cnt == DP - 1) m_full = 1;
         m_cnt = (m_cnt + 1) % DP;
      end
   endtask

   task automatic win_write(bit word);
      win_wr = 1; win_word = word;
      cyc();
      idle();
      if (word && !m_armed) begin
         m_locked = 0; m_half = 0;
         m_rptr = m_full ? m_cnt : 0;
      end
   endtask

   task automatic win_read(bit word, string req);
      bit ok;
      logic [BW-1:0] e;
      win_rd = 1; win_word = word;
      #5;
      ok = word && src_en && !m_armed && !m_locked;
      e  = ok ? exp_word(m_mem[m_rptr], m_half) : '0;
      chk(req, 32'(win_rdata), 32'(e));
      if (ok) begin
         if (m_half) m_rptr = (m_rptr + 1) % DP;
         m_half = !m_half;
      end
      cyc();
      idle();
   endtask

   task automatic chk_state(string req);
      #5;
      chk(req, 32'(cnt_o), 32'(m_cnt));
      chk(req, 32'(full_o), 32'(m_full));
      chk({req, "/R12"}, 32'(stat_o), {24'h0, m_full, 6'h0, m_armed});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      src_en = 1; trc_line = '0;
      @(negedge clk);
      do_por();
      chk_state("R11 por");
      win_read(1, "R8 locked after por");

      // short capture
      arm_wr(1, 0);
      chk_state("R3 armed");
      for (int i = 0; i < 10; i++) begin
         push(LW'($urandom));
         if ($urandom_range(1, 0) == 1) cyc();
      end
      chk_state("R1 count");
      win_write(1);                       // armed: no unlock
      win_read(1, "R5 armed read");
      arm_wr(0, 0);
      push(LW'($urandom)); push(LW'($urandom));
      chk_state("R4 disarmed ignore");
      win_read(1, "R8 still locked");
      win_write(0);                       // narrow write: no unlock
      win_read(1, "R8 narrow write no unlock");
      win_write(1);
      win_read(0, "R7 narrow read");
      src_en = 0;
      win_read(1, "R6 src off");
      src_en = 1;
      win_rd = 1; win_wr = 1; #5;
      chk("R8 read with write", 32'(win_rdata), 32'h0);
      cyc(); idle(); m_half = 0; m_rptr = 0;
      for (int i = 0; i < 10; i++) begin
         win_read(1, "R9 upper"); win_read(1, "R9 lower");
      end
      chk_state("R4 reads keep count");

      // system reset keeps session
      do_sysrst();
      chk_state("R11 sysrst keep");
      chk("R11 disarmed", 32'(armed_o), 32'h0);
      win_read(1, "R11 locked after sysrst");
      win_write(1);
      win_read(1, "R11 contents kept"); win_read(1, "R11 contents kept lo");

      // arm clears, same-cycle line dropped
      arm_wr(1, 0);
      push(LW'($urandom));
      arm_wr(1, 1);
      chk_state("R3 rearm drop");

      // overfill: 70 lines
      for (int i = 0; i < 70; i++) push(LW'($urandom));
      chk_state("R2 wrap full");
      arm_wr(0, 0);
      win_write(1);
      for (int i = 0; i < DP + 2; i++) begin
         win_read(1, "R10 oldest first"); win_read(1, "R9 wrap lower");
      end
      chk_state("R2 full kept");

      // random sessions
      for (int s = 0; s < 6; s++) begin
         int n;
         n = $urandom_range(130, 1);
         arm_wr(1, $urandom_range(1, 0) == 1);
         for (int i = 0; i < n; i++) begin
            push(LW'($urandom));
            if ($urandom_range(3, 0) == 0) win_read(1, "R5 random armed");
         end
         chk_state("R1 random count");
         arm_wr(0, 0);
         win_write(1);
         for (int i = 0; i < (m_full ? DP : m_cnt); i++) begin
            if ($urandom_range(4, 0) == 0) win_read(0, "R7 random narrow");
            win_read(1, "R9 random hi"); win_read(1, "R9 random lo");
         end
      end

      arm_wr(1, 0);
      for (int i = 0; i < 64; i++) push(LW'($urandom));
      chk_state("R2 exact 64");
      do_por();
      chk_state("R11 por clears");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule